// File: doc/BRIEF.md
# Prescaled Message Time Stamp Counter

This block keeps the time base that a CAN controller attaches to its messages. A 16-bit counter advances once every N pulses of the bus bit-clock enable, where N is 1, 2, 3 or 4 as chosen by a 2-bit ratio input. The count runs only while the controller's two reset control bits are both low. It can be cleared in two ways: by driving both of those bits high, or by a one-cycle software clear pulse. Each clear also restarts the ratio divider.

When the protocol engine reports a finished transfer, the block emits a single-cycle write on its stamp port. The write carries the count and the index of the message slot that the transfer belongs to, and the message store outside this block takes it. Which finished transfers produce a write depends on the loopback flag. In normal operation, every finished transmit and every finished receive is stamped. In loopback, only a finished receive is stamped, and only when its target slot can accept the message.

Top module: `ts_stamp_top`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted, and on the first cycle after it is released, `count` is 0x0000 and `stamp_vld` is 0.
- R2: While `ctl_rst` is 2'b00, `count` advances by one for every (`pre_sel`+1) cycles in which `bit_tick` is 1. The values 0, 1, 2 and 3 of `pre_sel` select ratios of 1, 2, 3 and 4. Cycles with `bit_tick` at 0 do not count toward the ratio.
- R3: While `ctl_rst` is 2'b01 or 2'b10, `count` holds its value and `bit_tick` has no effect on it.
- R4: `ctl_rst` equal to 2'b11 clears `count` to 0x0000 at the next clock edge. It stays 0 for as long as that value is held.
- R5: A one-cycle pulse on `cnt_clr` clears `count` to 0x0000 at the next edge. This happens even if an increment was due in the same cycle.
- R6: Every clear (R4, R5) also restarts the ratio divider. The first increment after a clear therefore needs a full (`pre_sel`+1) `bit_tick` pulses.
- R7: An increment from 0xFFFF gives 0x0000.
- R8: With `loopback` at 0, a 1 on `tx_done` or `rx_done` causes `stamp_vld` to be 1 in the next cycle. In that cycle, `stamp_slot` equals the `slot_idx` that was sampled and `stamp_data` equals the `count` that was sampled. `slot_free` is ignored.
- R9: With `loopback` at 1, a `tx_done` alone produces no stamp write.
- R10: With `loopback` at 1, `rx_done` produces a stamp write only when `slot_free` is 1 in the same cycle.
- R11: When a stamp capture and an increment fall in the same cycle, `stamp_data` holds the value from before the increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle enable per CAN bit-clock period |
| pre_sel | input | 2 | Ratio select; the ratio is pre_sel+1 |
| ctl_rst | input | 2 | Controller reset bits: 00 run, 01/10 hold, 11 clear |
| cnt_clr | input | 1 | Software clear pulse for the counter |
| loopback | input | 1 | Loopback mode flag |
| tx_done | input | 1 | Transmit finished pulse |
| rx_done | input | 1 | Receive finished pulse |
| slot_idx | input | 5 | Message slot of the finished transfer |
| slot_free | input | 1 | Target receive slot can accept the message |
| count | output | 16 | Current time stamp value |
| stamp_vld | output | 1 | Stamp write strobe |
| stamp_slot | output | 5 | Slot index for the stamp write |
| stamp_data | output | 16 | Time stamp value to store |

## Verification
The properties assume the following about the inputs: `tx_done` and `rx_done` are single-cycle strobes, `slot_idx` is valid whenever either strobe is high, and `cnt_clr` is a one-cycle pulse, not a level. The directed tasks drive each strobe high for exactly one cycle with a defined slot index. They raise `cnt_clr` for a single cycle only, and they change `pre_sel` only directly after a clear, never in the middle of a divider period. This keeps the ratio checks unambiguous.

// File: rtl/ts_pkg.sv
package ts_pkg;
  // Encoding of the two controller reset bits
  typedef enum logic [1:0] {
    CTL_RUN   = 2'b00,
    CTL_HOLDA = 2'b01,
    CTL_HOLDB = 2'b10,
    CTL_CLEAR = 2'b11
  } ctl_e;

  // Decide whether a finished transfer is stamped
  function automatic logic stamp_wanted(input logic lb, input logic tx,
                                        input logic rx, input logic free);
    if (lb) return rx & free;
    return tx | rx;
  endfunction
endpackage

// File: rtl/ts_prescaler.sv
module ts_prescaler #(
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             tick_in,
  input  logic [PRE_W-1:0] sel,
  output logic             step
);
  logic [PRE_W-1:0] phase;
  logic             last;

  assign last = (phase >= sel);
  assign step = run & tick_in & last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= '0;
    end else if (run && tick_in) begin
      if (last) phase <= '0;
      else      phase <= phase + PRE_W'(1);
    end
  end
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst || clr)  value <= '0;
    else if (step)   value <= value + CNT_W'(1);
  end
endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
  parameter int CNT_W  = 16,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [CNT_W-1:0]  now,
  input  logic [SLOT_W-1:0] slot,
  output logic              wr_vld,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [CNT_W-1:0]  wr_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_vld  <= 1'b0;
      wr_slot <= '0;
      wr_data <= '0;
    end else begin
      wr_vld <= fire;
      if (fire) begin
        wr_slot <= slot;
        wr_data <= now;
      end
    end
  end
endmodule

// File: rtl/ts_stamp_top.sv
module ts_stamp_top #(
  parameter int CNT_W  = 16,
  parameter int SLOT_W = 5,
  parameter int PRE_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [PRE_W-1:0]  pre_sel,
  input  logic [1:0]        ctl_rst,
  input  logic              cnt_clr,
  input  logic              loopback,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic              slot_free,
  output logic [CNT_W-1:0]  count,
  output logic              stamp_vld,
  output logic [SLOT_W-1:0] stamp_slot,
  output logic [CNT_W-1:0]  stamp_data
);
  import ts_pkg::*;

  ctl_e ctl;
  logic run, clr, step, fire;

  assign ctl  = ctl_e'(ctl_rst);
  assign run  = (ctl == CTL_RUN);
  assign clr  = (ctl == CTL_CLEAR) | cnt_clr;
  assign fire = stamp_wanted(loopback, tx_done, rx_done, slot_free);

  ts_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(clr), .run(run),
    .tick_in(bit_tick), .sel(pre_sel), .step(step)
  );

  ts_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .step(step), .value(count)
  );

  ts_capture #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_cap (
    .clk(clk), .rst(rst), .fire(fire), .now(count), .slot(slot_idx),
    .wr_vld(stamp_vld), .wr_slot(stamp_slot), .wr_data(stamp_data)
  );
endmodule

// File: rtl/ts_stamp_chk.sv
module ts_stamp_chk #(
  parameter int CNT_W  = 16,
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        ctl_rst,
  input logic              cnt_clr,
  input logic              loopback,
  input logic              tx_done,
  input logic              rx_done,
  input logic [SLOT_W-1:0] slot_idx,
  input logic              slot_free,
  input logic [CNT_W-1:0]  count,
  input logic              stamp_vld,
  input logic [SLOT_W-1:0] stamp_slot,
  input logic [CNT_W-1:0]  stamp_data
);
  // R2 R7
  step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (count == $past(count) + CNT_W'(1)) || (count == '0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_rst == 2'b01 || ctl_rst == 2'b10) && !cnt_clr |=> $stable(count));

  // R4
  ctl_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_rst == 2'b11) |=> (count == '0));

  // R5
  sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (count == '0));

  // R8
  normal_stamp_chk: assert property (@(posedge clk) disable iff (rst)
    (!loopback && (tx_done || rx_done)) |=>
      stamp_vld && (stamp_data == $past(count)) && (stamp_slot == $past(slot_idx)));

  // R9
  lb_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (loopback && tx_done && !rx_done) |=> !stamp_vld);

  // R10
  lb_full_chk: assert property (@(posedge clk) disable iff (rst)
    (loopback && !slot_free) |=> !stamp_vld);
endmodule

bind ts_stamp_top ts_stamp_chk #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_rst(ctl_rst), .cnt_clr(cnt_clr),
  .loopback(loopback), .tx_done(tx_done), .rx_done(rx_done),
  .slot_idx(slot_idx), .slot_free(slot_free), .count(count),
  .stamp_vld(stamp_vld), .stamp_slot(stamp_slot), .stamp_data(stamp_data)
);

// File: tb/ts_stamp_top_tb.sv
module ts_stamp_top_tb;
  logic        clk = 1'b0;
  logic        rst, bit_tick, cnt_clr, loopback, tx_done, rx_done, slot_free;
  logic [1:0]  pre_sel, ctl_rst;
  logic [4:0]  slot_idx;
  logic [15:0] count, stamp_data;
  logic        stamp_vld;
  logic [4:0]  stamp_slot;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  ts_stamp_top u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .pre_sel(pre_sel),
    .ctl_rst(ctl_rst), .cnt_clr(cnt_clr), .loopback(loopback),
    .tx_done(tx_done), .rx_done(rx_done), .slot_idx(slot_idx),
    .slot_free(slot_free), .count(count), .stamp_vld(stamp_vld),
    .stamp_slot(stamp_slot), .stamp_data(stamp_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    bit_tick = 1'b1; cyc(n); bit_tick = 1'b0;
  endtask

  task automatic sw_clear();
    cnt_clr = 1'b1; cyc(); cnt_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; bit_tick = 1'b1; cyc(3);
    chk("R1 count in reset", count, 0);
    chk("R1 vld in reset", stamp_vld, 0);
    rst = 1'b0; bit_tick = 1'b0; cyc();
    chk("R1 count after release", count, 0);
  endtask

  task automatic t_ratio();
    for (int s = 0; s < 4; s++) begin
      pre_sel = s[1:0]; sw_clear();
      ticks(3 * (s + 1));
      chk($sformatf("R2 ratio %0d", s + 1), count, 3);
    end
    pre_sel = 2'd1; sw_clear();
    for (int i = 0; i < 4; i++) begin ticks(1); cyc(2); end
    chk("R2 gapped ticks", count, 2);
  endtask

  task automatic t_hold_clear();
    pre_sel = 2'd0; sw_clear(); ticks(5);
    ctl_rst = 2'b01; ticks(4);
    chk("R3 hold 01", count, 5);
    ctl_rst = 2'b10; ticks(4);
    chk("R3 hold 10", count, 5);
    ctl_rst = 2'b11; ticks(3);
    chk("R4 ctl clear", count, 0);
    ctl_rst = 2'b00; ticks(2);
    chk("R4 runs after clear", count, 2);
    bit_tick = 1'b1; cnt_clr = 1'b1; cyc(); cnt_clr = 1'b0; bit_tick = 1'b0;
    chk("R5 sw clear beats step", count, 0);
  endtask

  task automatic t_div_restart();
    pre_sel = 2'd3; sw_clear();
    ticks(2);
    sw_clear();
    ticks(3);
    chk("R6 no step before full period", count, 0);
    ticks(1);
    chk("R6 step after full period", count, 1);
  endtask

  task automatic t_wrap();
    pre_sel = 2'd0; sw_clear();
    ticks(65535);
    chk("R7 reach FFFF", count, 16'hFFFF);
    ticks(1);
    chk("R7 wrap", count, 0);
  endtask

  task automatic t_normal();
    pre_sel = 2'd0; loopback = 1'b0; sw_clear(); ticks(5);
    tx_done = 1'b1; slot_idx = 5'd7; slot_free = 1'b0; cyc(); tx_done = 1'b0;
    chk("R8 tx vld", stamp_vld, 1);
    chk("R8 tx data", stamp_data, 5);
    chk("R8 tx slot", stamp_slot, 7);
    cyc();
    chk("R8 single strobe", stamp_vld, 0);
    rx_done = 1'b1; slot_idx = 5'd3; bit_tick = 1'b1; cyc();
    rx_done = 1'b0; bit_tick = 1'b0;
    chk("R11 pre-increment data", stamp_data, 5);
    chk("R11 count moved", count, 6);
    chk("R8 rx slot", stamp_slot, 3);
  endtask

  task automatic t_loop();
    loopback = 1'b1; slot_free = 1'b1;
    tx_done = 1'b1; slot_idx = 5'd9; cyc(); tx_done = 1'b0;
    chk("R9 lb tx no stamp", stamp_vld, 0);
    rx_done = 1'b1; slot_free = 1'b0; cyc(); rx_done = 1'b0;
    chk("R10 lb rx slot busy", stamp_vld, 0);
    rx_done = 1'b1; slot_free = 1'b1; slot_idx = 5'd30; cyc(); rx_done = 1'b0;
    chk("R10 lb rx vld", stamp_vld, 1);
    chk("R10 lb rx slot", stamp_slot, 30);
    chk("R10 lb rx data", stamp_data, 6);
    loopback = 1'b0;
  endtask

  initial begin
    rst = 1'b1; bit_tick = 0; cnt_clr = 0; loopback = 0; tx_done = 0;
    rx_done = 0; slot_free = 0; pre_sel = 0; ctl_rst = 0; slot_idx = 0;
    cyc();
    t_reset();
    t_ratio();
    t_hold_clear();
    t_div_restart();
    t_wrap();
    t_normal();
    t_loop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule